// File: doc/BRIEF.md
# Down-Spread Clock Modulation Profile Generator

This block produces the digital frequency-offset profile that a fractional divider or numerically controlled oscillator uses to spread a clock's spectrum. It runs on the reference clock it modulates. Every cycle it outputs a signed offset word, in fixed-point fractions of nominal frequency, and a flag that is high while spreading is applied. The profile is a symmetric triangle that only ever pulls the frequency below nominal. It reaches zero, which is the nominal frequency, once per modulation period.

A 2-bit select chooses no spreading or a peak depth of 1 %, 2 % or 3 %. The modulation period is a fixed number of reference cycles: 625 by default, which gives 32 kHz from a 20 MHz reference. The logic counts cycles only, so the depth does not change with the reference frequency, anywhere from 15 MHz to 60 MHz. A new select value is applied only where the offset is zero, so the profile never jumps.

Offset scaling: the word is two's complement, and -65536 would stand for -100 % of nominal.

Top module: `ssm_profile_gen`

## Requirements
- R1: While the applied select is 00 (off), `freq_offset` is exactly 0 and `spread_on` is 0.
- R2: Applied select codes 01, 10 and 11 give peak offsets of -655, -1311 and -1966 (1 %, 2 % and 3 % of 65536). The peak appears at phases 312 and 313.
- R3: `freq_offset` is never above 0. At phase t it equals -floor(P*T(t)/312), where P is the peak magnitude from R2, T(t)=t for t<=312, and T(t)=625-t otherwise.
- R4: While spreading is on, the phase advances by one each cycle and wraps from 624 to 0. The offset is 0 at phase 0, so the profile repeats every 625 cycles.
- R5: While spreading is on, a change of `spread_sel` is applied only on the wrap from phase 624 to 0. While spreading is off, the select is applied at the next clock edge, and the profile starts at phase 0.
- R6: A cycle with `rst` high clears the phase to 0, sets the applied select to off, forces `freq_offset` to 0 and drives `spread_on` to 0 on the next cycle.
- R7: `spread_on` is 1 exactly when the applied select is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock being spread |
| rst | input | 1 | Synchronous active-high reset |
| spread_sel | input | 2 | Depth select: 00 off, 01 1 %, 10 2 %, 11 3 % |
| freq_offset | output | 16 | Signed offset, -65536 = -100 % of nominal |
| spread_on | output | 1 | High while a nonzero depth is applied |

## Verification
The assertions assume that `spread_sel` is a clean level sampled on the reference clock, and that `rst` is held high at time zero so that the phase and the applied select start from known values. The stimulus drives the select and reset only at falling edges. It begins every run in reset, and it holds each random select value for a random span of 1 to 900 cycles, so changes land both mid-profile and at the wrap. Rare random resets cut into active profiles, to cover the assertions' reset-relative windows.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

    typedef enum logic [1:0] {
        SPREAD_OFF = 2'b00,
        SPREAD_LO  = 2'b01,
        SPREAD_MID = 2'b10,
        SPREAD_HI  = 2'b11
    } spread_e;

    typedef enum logic [1:0] {
        STEP_CLEAR,
        STEP_UP,
        STEP_HOLD,
        STEP_DOWN
    } step_e;

    // Peak magnitude for a depth code: level percent of 2**frac_w, rounded.
    function automatic int peak_code(input int level, input int frac_w);
        return (level * (1 << frac_w) + 50) / 100;
    endfunction

    // Triangle position for a phase within the modulation period.
    function automatic int tri_pos(input int p, input int period);
        int half;
        half = period / 2;
        return (p <= half) ? p : (period - p);
    endfunction

endpackage

// File: rtl/ssm_phase.sv
module ssm_phase
    import ssm_pkg::*;
#(
    parameter int PERIOD = 625,
    parameter int PH_W   = $clog2(PERIOD)
) (
    input  logic            clk,
    input  logic            rst,
    input  spread_e         sel_in,
    output logic [PH_W-1:0] phase_o,
    output spread_e         sel_o,
    output step_e           step_o
);
    localparam logic [PH_W-1:0] LAST = PH_W'(PERIOD - 1);

    logic [PH_W-1:0] phase_q, phase_n;
    spread_e         sel_q, sel_n;
    step_e           step_n;

    always_comb begin
        if (sel_q == SPREAD_OFF) begin
            phase_n = '0;
            sel_n   = sel_in;
        end else if (phase_q == LAST) begin
            phase_n = '0;
            sel_n   = sel_in;
        end else begin
            phase_n = phase_q + PH_W'(1);
            sel_n   = sel_q;
        end
    end

    always_comb begin
        int t_now, t_next;
        t_now  = tri_pos(int'(phase_q), PERIOD);
        t_next = tri_pos(int'(phase_n), PERIOD);
        if (phase_n == '0)
            step_n = STEP_CLEAR;
        else if (t_next > t_now)
            step_n = STEP_UP;
        else if (t_next == t_now)
            step_n = STEP_HOLD;
        else
            step_n = STEP_DOWN;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            sel_q   <= SPREAD_OFF;
        end else begin
            phase_q <= phase_n;
            sel_q   <= sel_n;
        end
    end

    assign phase_o = phase_q;
    assign sel_o   = sel_q;
    assign step_o  = step_n;

    // R4: the phase wraps to zero after its last value
    a_r4_phase_wrap: assert property (@(posedge clk) disable iff (rst)
        (sel_q != SPREAD_OFF && phase_q == LAST) |=> (phase_q == '0));

    // R4: the phase counts up by one while active
    a_r4_phase_count: assert property (@(posedge clk) disable iff (rst)
        (sel_q != SPREAD_OFF && phase_q != LAST && sel_in != SPREAD_OFF)
        |=> (phase_q == $past(phase_q) + PH_W'(1)));

    // R5: the applied select holds except at the wrap
    a_r5_sel_hold: assert property (@(posedge clk) disable iff (rst)
        (sel_q != SPREAD_OFF && phase_q != LAST) |=> $stable(sel_q));

    // R5: an off state restarts the phase at zero
    a_r5_off_restart: assert property (@(posedge clk) disable iff (rst)
        (sel_q == SPREAD_OFF) |=> (phase_q == '0));

endmodule

// File: rtl/ssm_depth_table.sv
module ssm_depth_table
    import ssm_pkg::*;
#(
    parameter int OFS_W  = 16,
    parameter int FRAC_W = 16,
    parameter int HALF   = 312,
    parameter int REM_W  = $clog2(HALF) + 1
) (
    input  spread_e          sel_i,
    output logic [OFS_W-1:0] quot_o,
    output logic [REM_W-1:0] rem_o,
    output logic [OFS_W-1:0] peak_o
);
    localparam int LEVELS = 4;

    logic [OFS_W-1:0] quot_tab [LEVELS];
    logic [REM_W-1:0] rem_tab  [LEVELS];
    logic [OFS_W-1:0] peak_tab [LEVELS];

    for (genvar i = 0; i < LEVELS; i++) begin : g_level
        localparam int PK = peak_code(i, FRAC_W);
        assign peak_tab[i] = OFS_W'(PK);
        assign quot_tab[i] = OFS_W'(PK / HALF);
        assign rem_tab[i]  = REM_W'(PK % HALF);
    end

    assign quot_o = quot_tab[sel_i];
    assign rem_o  = rem_tab[sel_i];
    assign peak_o = peak_tab[sel_i];

endmodule

// File: rtl/ssm_tri_dda.sv
module ssm_tri_dda
    import ssm_pkg::*;
#(
    parameter int OFS_W = 16,
    parameter int HALF  = 312,
    parameter int REM_W = $clog2(HALF) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  step_e            step_i,
    input  logic [OFS_W-1:0] quot_i,
    input  logic [REM_W-1:0] rem_i,
    output logic [OFS_W-1:0] mag_o
);
    localparam logic signed [REM_W:0] HALF_S = (REM_W + 1)'(HALF);

    logic [OFS_W-1:0]     mag_q, mag_n;
    logic [REM_W-1:0]     rem_q, rem_n;
    logic signed [REM_W:0] acc;

    always_comb begin
        mag_n = mag_q;
        rem_n = rem_q;
        acc   = '0;
        unique case (step_i)
            STEP_CLEAR: begin
                mag_n = '0;
                rem_n = '0;
            end
            STEP_UP: begin
                acc = $signed({1'b0, rem_q}) + $signed({1'b0, rem_i});
                if (acc >= HALF_S) begin
                    rem_n = REM_W'(acc - HALF_S);
                    mag_n = mag_q + quot_i + OFS_W'(1);
                end else begin
                    rem_n = REM_W'(acc);
                    mag_n = mag_q + quot_i;
                end
            end
            STEP_DOWN: begin
                acc = $signed({1'b0, rem_q}) - $signed({1'b0, rem_i});
                if (acc < 0) begin
                    rem_n = REM_W'(acc + HALF_S);
                    mag_n = mag_q - quot_i - OFS_W'(1);
                end else begin
                    rem_n = REM_W'(acc);
                    mag_n = mag_q - quot_i;
                end
            end
            default: begin
                mag_n = mag_q;
                rem_n = rem_q;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mag_q <= '0;
            rem_q <= '0;
        end else begin
            mag_q <= mag_n;
            rem_q <= rem_n;
        end
    end

    assign mag_o = mag_q;

    // R3: the remainder stays below the half-period
    a_r3_rem_range: assert property (@(posedge clk) disable iff (rst)
        (int'(rem_q) < HALF));

    // R2: the flat top keeps the peak for one more cycle
    a_r2_hold_flat: assert property (@(posedge clk) disable iff (rst)
        (step_i == STEP_HOLD) |=> $stable(mag_q));

    // R4: a restart brings the magnitude back to zero
    a_r4_clear_zero: assert property (@(posedge clk) disable iff (rst)
        (step_i == STEP_CLEAR) |=> (mag_q == '0));

endmodule

// File: rtl/ssm_profile_gen.sv
module ssm_profile_gen
    import ssm_pkg::*;
#(
    parameter int OFS_W      = 16,
    parameter int FRAC_W     = 16,
    parameter int MOD_PERIOD = 625
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       spread_sel,
    output logic [OFS_W-1:0] freq_offset,
    output logic             spread_on
);
    localparam int HALF  = MOD_PERIOD / 2;
    localparam int PH_W  = $clog2(MOD_PERIOD);
    localparam int REM_W = $clog2(HALF) + 1;

    logic [PH_W-1:0]  phase;
    spread_e          sel_applied;
    step_e            step;
    logic [OFS_W-1:0] quot, peak, mag;
    logic [REM_W-1:0] rem_step;

    ssm_phase #(
        .PERIOD (MOD_PERIOD),
        .PH_W   (PH_W)
    ) u_phase (
        .clk     (clk),
        .rst     (rst),
        .sel_in  (spread_e'(spread_sel)),
        .phase_o (phase),
        .sel_o   (sel_applied),
        .step_o  (step)
    );

    ssm_depth_table #(
        .OFS_W  (OFS_W),
        .FRAC_W (FRAC_W),
        .HALF   (HALF),
        .REM_W  (REM_W)
    ) u_table (
        .sel_i  (sel_applied),
        .quot_o (quot),
        .rem_o  (rem_step),
        .peak_o (peak)
    );

    ssm_tri_dda #(
        .OFS_W (OFS_W),
        .HALF  (HALF),
        .REM_W (REM_W)
    ) u_dda (
        .clk    (clk),
        .rst    (rst),
        .step_i (step),
        .quot_i (quot),
        .rem_i  (rem_step),
        .mag_o  (mag)
    );

    assign freq_offset = OFS_W'(0) - mag;
    assign spread_on   = (sel_applied != SPREAD_OFF);

    // R1: off means zero offset
    a_r1_off_zero: assert property (@(posedge clk) disable iff (rst)
        !spread_on |-> (freq_offset == '0));

    // R3: the offset never rises above nominal
    a_r3_not_positive: assert property (@(posedge clk) disable iff (rst)
        !($signed(freq_offset) > 0));

    // R2: the depth never exceeds the selected peak
    a_r2_within_peak: assert property (@(posedge clk) disable iff (rst)
        (mag <= peak));

    // R4: the offset is zero at phase zero
    a_r4_zero_at_origin: assert property (@(posedge clk) disable iff (rst)
        (phase == '0) |-> (freq_offset == '0));

    // R6: reset clears the outputs on the next cycle
    a_r6_reset_clear: assert property (@(posedge clk)
        rst |=> (freq_offset == '0 && !spread_on));

endmodule

// File: tb/tb_ssm_profile_gen.sv
`timescale 1ns/1ps
module tb_ssm_profile_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  sel = 2'b00;
    logic [15:0] offs;
    logic        son;

    int checks   = 0;
    int failures = 0;
    int m_sel    = 0;
    int m_phase  = 0;
    logic m_rst_prev = 1'b1;
    bit   wd_hit = 1'b0;
    int unsigned seed_val = 32'd1234;

    always #10 clk = ~clk;

    ssm_profile_gen dut (
        .clk         (clk),
        .rst         (rst),
        .spread_sel  (sel),
        .freq_offset (offs),
        .spread_on   (son)
    );

    function automatic int peak_of(input int s);
        case (s)
            1: return 655;
            2: return 1311;
            3: return 1966;
            default: return 0;
        endcase
    endfunction

    function automatic int tri_of(input int p);
        return (p <= 312) ? p : 625 - p;
    endfunction

    function automatic int exp_offset();
        if (m_sel == 0) return 0;
        return -((peak_of(m_sel) * tri_of(m_phase)) / 312);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s phase=%0d sel=%0d actual=%0d expected=%0d",
                     req, m_phase, m_sel, act, exp);
        end
    endtask

    task automatic model_step(input logic r, input logic [1:0] s);
        m_rst_prev = r;
        if (r) begin
            m_sel = 0; m_phase = 0;
        end else if (m_sel == 0) begin
            m_sel = int'(s); m_phase = 0;
        end else if (m_phase == 624) begin
            m_sel = int'(s); m_phase = 0;
        end else begin
            m_phase++;
        end
    endtask

    task automatic check_outputs();
        string tag;
        if (m_rst_prev)                          tag = "R6";
        else if (m_sel == 0)                     tag = "R1";
        else if (m_phase == 312 || m_phase == 313) tag = "R2";
        else if (m_phase == 0)                   tag = "R4";
        else                                     tag = "R3";
        check(tag, int'($signed(offs)), exp_offset());
        check("R7", int'(son), (m_sel != 0) ? 1 : 0);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        model_step(rst, sel);
        @(negedge clk);
        check_outputs();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic run_to_phase(input int target);
        for (int i = 0; i < 2000; i++) begin
            if (m_phase == target && m_sel != 0) break;
            tick();
        end
    endtask

    task automatic main_seq();
        // R6: reset state
        rst = 1'b1; sel = 2'b00;
        run(3);
        check("R6", int'($signed(offs)), 0);
        check("R6", int'(son), 0);

        // R1: spreading off
        @(negedge clk); rst = 1'b0;
        run(40);
        check("R1", int'($signed(offs)), 0);

        // R2 / R3 / R4: each depth across a full period
        sel = 2'b01; run(700);
        sel = 2'b10; run_to_phase(624); tick();
        run_to_phase(312);
        check("R2", int'($signed(offs)), -1311);
        tick();
        check("R2", int'($signed(offs)), -1311);
        sel = 2'b11; run_to_phase(624); tick();
        run_to_phase(312);
        check("R2", int'($signed(offs)), -1966);
        run_to_phase(624); tick();
        check("R4", int'($signed(offs)), 0);

        // R5: mid-profile change waits for the wrap
        sel = 2'b01; run_to_phase(624); tick();
        run(100);
        sel = 2'b11;
        run_to_phase(312);
        check("R5", int'($signed(offs)), -655);
        run_to_phase(624); tick();
        run_to_phase(312);
        check("R5", int'($signed(offs)), -1966);

        // R5: return to off only at the wrap, then restart from off
        sel = 2'b00; run(20);
        check("R5", int'(son), 1);
        run_to_phase(624); tick();
        check("R1", int'(son), 0);
        sel = 2'b10; tick();
        check("R5", int'(son), 1);
        check("R5", m_phase, 0);

        // R6: reset in the middle of a profile
        run(200);
        rst = 1'b1; tick();
        check("R6", int'($signed(offs)), 0);
        rst = 1'b0; sel = 2'b11; run(50);

        // Random stimulus
        void'($urandom(seed_val));
        for (int seg = 0; seg < 60; seg++) begin
            int len;
            sel = 2'($urandom_range(0, 3));
            len = int'($urandom_range(1, 900));
            if ($urandom_range(0, 19) == 0) begin
                rst = 1'b1; tick(); rst = 1'b0;
            end
            run(len);
        end
    endtask

    initial begin
        fork
            begin
                main_seq();
            end
            begin
                repeat (200000) @(posedge clk);
                wd_hit = 1'b1;
            end
        join_any
        disable fork;
        if (wd_hit) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=expired expected=finished");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule